// File: doc/BRIEF.md
# Partitioned Saturating SIMD Adder

This block adds or subtracts two 64-bit words whose carry path can be cut into independent lanes. A lane-size select treats the word as eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Every lane is computed at once by a single carry chain built from 8-bit granules. A granule at the start of a lane takes its carry-in from the add/subtract select and not from its lower neighbour. Subtraction adds the inverted second operand, and each lane start receives its own +1.

Each lane reports overflow according to the signed/unsigned select. When the saturate enable is low, the lane keeps its two's-complement wrapped result. When it is high, an overflowing lane is clamped to the limit in the direction of the overflow. Operations enter through a valid/ready input and leave through a registered valid/ready output. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output holds its value and a new operation is taken only after the held one is consumed.

Top module: `simd_sat_adder`

## Requirements
- R1: `in_lane_sel` encodes the lane width as 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. Lane j occupies bits [j*W +: W]. No carry or borrow crosses from one lane into the next.
- R2: With `in_sat` = 0, every lane result is the sum of its operand fields modulo 2^W, including lanes that overflow.
- R3: With `in_sub` = 1, every lane result is the difference a − b modulo 2^W, computed as a + ~b + 1 with the +1 applied separately to each lane.
- R4: In signed add mode, a lane overflows exactly when both operand fields have the same sign and the result sign differs. Operands of opposite sign never overflow.
- R5: In signed subtract mode, a lane overflows exactly when the operand signs differ and the result sign differs from the sign of a. Operands of the same sign never overflow.
- R6: In signed saturating mode, an overflowing lane becomes the largest positive value when a is non-negative, and the most negative value when a is negative.
- R7: In unsigned mode, add overflow is the lane carry-out and clamps the lane to all ones. Subtract overflow is the lane borrow and clamps the lane to zero.
- R8: `out_ovf` bit j is the overflow flag of lane j (lane 0 holds the least significant bits). Bits at or above the number of lanes are 0. Flags are reported whether or not saturation is enabled.
- R9: An accepted operation appears on `out_data`/`out_ovf` with `out_valid` high after exactly one clock edge.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_ovf` stay unchanged. `in_ready` equals `!out_valid || out_ready`.
- R11: During and right after reset, `out_valid`, `out_data` and `out_ovf` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| in_lane_sel | input | 2 | Lane width select (R1 encoding) |
| in_sub | input | 1 | 1 = subtract, 0 = add |
| in_sat | input | 1 | 1 = saturate on overflow |
| in_signed | input | 1 | 1 = signed lanes, 0 = unsigned |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Lane results |
| out_ovf | output | 8 | Per-lane overflow flags |

## Verification
The bench builds the block with its default parameters: a 64-bit word made of 8-bit granules. With these defaults all four lane widths can be reached, from eight one-byte lanes down to the single full-word lane that drives only flag bit 0. A separately written lane model gives the expected values. Directed vectors place carries exactly at lane edges and drive each signed and unsigned overflow direction, with and without clamping. A long mixed phase stalls `out_ready` at random to test holding and back-to-back acceptance.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  typedef enum logic [1:0] {
    LS_8  = 2'd0,
    LS_16 = 2'd1,
    LS_32 = 2'd2,
    LS_64 = 2'd3
  } lane_size_e;

  localparam int NUM_LANE_SIZES = 4;

endpackage

// File: rtl/simd_carry_part.sv
module simd_carry_part
  import simd_add_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int GRAN_W = 8
) (
  input  logic [DATA_W-1:0]        a,
  input  logic [DATA_W-1:0]        b,
  input  lane_size_e               lane_sel,
  input  logic                     sub,
  output logic [DATA_W-1:0]        sum,
  output logic [DATA_W/GRAN_W-1:0] gcarry,
  output logic [DATA_W/GRAN_W-1:0] a_msb,
  output logic [DATA_W/GRAN_W-1:0] b_msb
);

  localparam int NB = DATA_W / GRAN_W;

  logic [DATA_W-1:0] b_eff;
  logic [NB-1:0]     lane_first;

  assign b_eff = sub ? ~b : b;

  // a granule starts a lane when its index is a multiple of the lane size in granules
  generate
    for (genvar g = 0; g < NB; g++) begin : g_first
      assign lane_first[g] = ((g % (1 << int'(lane_sel))) == 0);
      assign a_msb[g]      = a[g*GRAN_W + GRAN_W - 1];
      assign b_msb[g]      = b_eff[g*GRAN_W + GRAN_W - 1];
    end
  endgenerate

  always_comb begin
    logic            c;
    logic [GRAN_W:0] part;
    c    = 1'b0;
    part = '0;
    sum  = '0;
    for (int g = 0; g < NB; g++) begin
      if (lane_first[g]) c = sub;
      part = {1'b0, a[g*GRAN_W +: GRAN_W]} + {1'b0, b_eff[g*GRAN_W +: GRAN_W]}
           + {{GRAN_W{1'b0}}, c};
      sum[g*GRAN_W +: GRAN_W] = part[GRAN_W-1:0];
      c         = part[GRAN_W];
      gcarry[g] = c;
    end
  end

endmodule

// File: rtl/simd_lane_sat.sv
module simd_lane_sat
  import simd_add_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int GRAN_W = 8
) (
  input  logic [DATA_W-1:0]        sum,
  input  logic [DATA_W/GRAN_W-1:0] gcarry,
  input  logic [DATA_W/GRAN_W-1:0] a_msb,
  input  logic [DATA_W/GRAN_W-1:0] b_msb,
  input  lane_size_e               lane_sel,
  input  logic                     sub,
  input  logic                     sat,
  input  logic                     sgn,
  output logic [DATA_W-1:0]        res,
  output logic [DATA_W/GRAN_W-1:0] ovf
);

  localparam int NB = DATA_W / GRAN_W;
  localparam int NS = NUM_LANE_SIZES;

  logic [NS-1:0][DATA_W-1:0] res_m;
  logic [NS-1:0][NB-1:0]     ovf_m;

  generate
    for (genvar m = 0; m < NS; m++) begin : g_mode
      localparam int LB = 1 << m;
      localparam int LW = LB * GRAN_W;
      localparam int NL = (NB >= LB) ? NB / LB : 0;
      if (NL == 0) begin : g_none
        assign res_m[m] = sum;
        assign ovf_m[m] = '0;
      end else begin : g_lanes
        for (genvar j = 0; j < NL; j++) begin : g_lane
          localparam int TG = j*LB + LB - 1;
          logic          sa, sb, sr, ov;
          logic [LW-1:0] clamp;
          assign sa = a_msb[TG];
          assign sb = b_msb[TG];
          assign sr = sum[j*LW + LW - 1];
          // signed: same-sign inputs (after inversion for subtract) with a sign change
          // unsigned: carry-out on add, missing carry (borrow) on subtract
          assign ov = sgn ? ((sa == sb) && (sr != sa)) : (gcarry[TG] ^ sub);
          always_comb begin
            if (sgn) clamp = sa ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
            else     clamp = sub ? '0 : '1;
          end
          assign res_m[m][j*LW +: LW] = (sat && ov) ? clamp : sum[j*LW +: LW];
          assign ovf_m[m][j]          = ov;
        end
        if (NL < NB) begin : g_pad
          assign ovf_m[m][NB-1:NL] = '0;
        end
      end
    end
  endgenerate

  assign res = res_m[lane_sel];
  assign ovf = ovf_m[lane_sel];

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_add_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int GRAN_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DATA_W-1:0]        in_a,
  input  logic [DATA_W-1:0]        in_b,
  input  logic [1:0]               in_lane_sel,
  input  logic                     in_sub,
  input  logic                     in_sat,
  input  logic                     in_signed,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [DATA_W-1:0]        out_data,
  output logic [DATA_W/GRAN_W-1:0] out_ovf
);

  localparam int NB = DATA_W / GRAN_W;

  lane_size_e        sel;
  logic [DATA_W-1:0] sum, res;
  logic [NB-1:0]     gcarry, a_msb, b_msb, ovf;
  logic              accept;

  assign sel = lane_size_e'(in_lane_sel);

  simd_carry_part #(.DATA_W(DATA_W), .GRAN_W(GRAN_W)) u_carry (
    .a(in_a), .b(in_b), .lane_sel(sel), .sub(in_sub),
    .sum(sum), .gcarry(gcarry), .a_msb(a_msb), .b_msb(b_msb)
  );

  simd_lane_sat #(.DATA_W(DATA_W), .GRAN_W(GRAN_W)) u_sat (
    .sum(sum), .gcarry(gcarry), .a_msb(a_msb), .b_msb(b_msb),
    .lane_sel(sel), .sub(in_sub), .sat(in_sat), .sgn(in_signed),
    .res(res), .ovf(ovf)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= res;
      out_ovf   <= ovf;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R9

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ovf))); // R10

  AST_MIXED_SIGN_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sel == LS_8 && in_signed && !in_sub && (in_a[7] != in_b[7])) |=> !out_ovf[0]); // R4

  AST_SAME_SIGN_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sel == LS_8 && in_signed && in_sub && (in_a[7] == in_b[7])) |=> !out_ovf[0]); // R5

  AST_UNSIGNED_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sel == LS_64 && !in_signed && !in_sub && in_sat
     && in_a[DATA_W-1] && in_b[DATA_W-1]) |=> (out_data == '1)); // R7

endmodule

// File: tb/simd_sat_adder_tb.sv
module simd_sat_adder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0, in_b = '0;
  logic [1:0]  in_lane_sel = '0;
  logic        in_sub = 1'b0, in_sat = 1'b0, in_signed = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic [7:0]  out_ovf;

  int  checks = 0;
  int  errors = 0;
  bit  stall_mode = 1'b0;

  typedef struct {
    logic [63:0] d;
    logic [7:0]  f;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  simd_sat_adder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_lane_sel(in_lane_sel), .in_sub(in_sub),
    .in_sat(in_sat), .in_signed(in_signed), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_ovf(out_ovf)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // lane model written from the requirements, using exact integer arithmetic
  function automatic void ref_op(input logic [63:0] a, input logic [63:0] b, input int sel,
                                 input bit sub, input bit sat, input bit sgn,
                                 output logic [63:0] r, output logic [7:0] f);
    int lw, nl;
    bit ov;
    logic signed [67:0] mask, x, y, sx, sy, ex, mx, mn, wr, cl, ln;
    lw = 8 << sel;
    nl = 64 / lw;
    r = '0;
    f = '0;
    mask = (68'sd1 <<< lw) - 68'sd1;
    for (int j = 0; j < nl; j++) begin
      x  = $signed({4'b0, a >> (j*lw)}) & mask;
      y  = $signed({4'b0, b >> (j*lw)}) & mask;
      wr = (sub ? x - y : x + y) & mask;
      if (sgn) begin
        sx = x[lw-1] ? x - (mask + 68'sd1) : x;
        sy = y[lw-1] ? y - (mask + 68'sd1) : y;
        ex = sub ? sx - sy : sx + sy;
        mx = (68'sd1 <<< (lw-1)) - 68'sd1;
        mn = -(mx + 68'sd1);
        ov = (ex > mx) || (ex < mn);
        cl = (ex > mx) ? mx : (mn & mask);
      end else begin
        ex = sub ? x - y : x + y;
        ov = (ex < 0) || (ex > mask);
        cl = sub ? 68'sd0 : mask;
      end
      ln = (sat && ov) ? cl : wr;
      r |= 64'(ln & mask) << (j*lw);
      f[j] = ov;
    end
  endfunction

  task automatic send(input logic [63:0] a, input logic [63:0] b, input int sel,
                      input bit sub, input bit sat, input bit sgn, input string tag);
    exp_t e;
    bit   acc;
    ref_op(a, b, sel, sub, sat, sgn, e.d, e.f);
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    in_a = a; in_b = b; in_lane_sel = 2'(sel);
    in_sub = sub; in_sat = sat; in_signed = sgn;
    in_valid = 1'b1;
    acc = 1'b0;
    while (!acc) begin
      #1;
      acc = in_ready;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
    #1;
    in_valid = 1'b0;
    chk("R9 out_valid after accept", 64'(out_valid), 64'd1);
  endtask

  always @(negedge clk) begin
    if (stall_mode) out_ready <= ($urandom % 3) != 0;
    else            out_ready <= 1'b1;
  end

  // monitor: compares consumed results with the scoreboard, watches holds
  bit          held = 1'b0;
  logic [63:0] held_d;
  logic [7:0]  held_f;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (held) begin
        chk("R10 valid held", 64'(out_valid), 64'd1);
        chk("R10 data held", out_data, held_d);
        chk("R10 flags held", 64'(out_ovf), 64'(held_f));
      end
      chk("R10 in_ready rule", 64'(in_ready), 64'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          chk("R9 unexpected output", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk({e.tag, " data"}, out_data, e.d);
          chk({e.tag, " flags R8"}, 64'(out_ovf), 64'(e.f));
        end
      end
      held   = out_valid && !out_ready;
      held_d = out_data;
      held_f = out_ovf;
    end
  end

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk("R11 reset out_valid", 64'(out_valid), 64'd0);
    chk("R11 reset out_data", out_data, 64'd0);
    chk("R11 reset out_ovf", 64'(out_ovf), 64'd0);
    chk("R11 reset in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: carries stop at each lane edge
    send(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 0, 0, 0, 0, "R1 byte lanes");
    send(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 1, 0, 0, 0, "R1 half lanes");
    send(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 1, 0, 0, 0, "R1 half wrap");
    send(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2, 0, 0, 0, "R1 word lanes");
    send(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 3, 0, 0, 0, "R1 dword lane");
    // R2: wrap when saturation off
    send(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 0, 0, 0, 1, "R2 signed wrap");
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, 3, 0, 0, 0, "R2 unsigned wrap");
    // R3: per-lane subtraction
    send(64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001, 1, 1, 0, 0, "R3 half sub");
    send(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 0, 1, 0, 1, "R3 byte sub");
    // R4: signed add overflow
    send(64'h4000_0000_C000_0000, 64'h4000_0000_C000_0000, 2, 0, 1, 1, "R4 R6 word add sat");
    send(64'h7F80_7F80_7F80_7F80, 64'h8080_8080_8080_8080, 0, 0, 1, 1, "R4 mixed signs");
    // R5: signed subtract overflow
    send(64'h7FFF_8000_0001_FFFF, 64'hFFFF_0001_0001_FFFF, 1, 1, 1, 1, "R5 R6 half sub sat");
    send(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 3, 1, 1, 1, "R5 R6 dword sub sat");
    // R7: unsigned clamps
    send(64'hF005_F005_F005_F005, 64'h2009_2009_2009_2009, 0, 0, 1, 0, "R7 byte add sat");
    send(64'hF005_F005_F005_F005, 64'h2009_2009_2009_2009, 0, 1, 1, 0, "R7 byte sub sat");
    send(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 3, 0, 1, 0, "R7 dword add sat");
    // R8: flags without clamping, lane count bounds
    send(64'h8000_0000_8000_0000, 64'h8000_0000_0000_0000, 2, 0, 0, 0, "R8 word flags");

    stall_mode = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (n % 4 == 1) rb = ra ^ 64'h8080_8080_8080_8080;
      if (n % 4 == 2) ra = 64'h7F7F_8080_7FFF_8000;
      send(ra, rb, int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
           "R3 mixed");
    end
    stall_mode = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule